// File: doc/BRIEF.md
# Two-Way Cache Block Lock Controller

This block holds the tag, valid, lock and replacement state of a small two-way set-associative data cache and carries out maintenance commands that software issues through an address register and a command write. Software loads the target address, then writes a four-bit command code together with the caching-inhibited attribute of that address. The block looks the address up against both ways of the indexed set. It can pin a block in the cache, release one block or all blocks, or drop every block that is not pinned.

When a pin request misses, the block chooses a victim way and raises a line-fill request carrying the line-aligned address. It stays busy until the memory side acknowledges the fill. It then installs the tag as valid and locked. Two sticky error flags record pin requests that could not be honoured. Software clears them with a write-one-to-clear strobe. A combinational probe port reports hit, way, lock and replacement pointer for any address, so the state arrays can be observed without touching them.

Top module: `cache_lock_ctrl`

## Requirements
- R1: Command codes are 4'b0110 load-and-lock, 4'b1000 unlock block, 4'b1010 unlock all and 4'b1100 invalidate all. Any other code written has no effect on state, errors or the fill port.
- R2: A load-and-lock that hits a way of the indexed set sets that block's lock bit at the clock edge that accepts the command. It raises no fill and no error, and the set's LRU bit then points to the other way.
- R3: A load-and-lock that misses, with the address cacheable and a replaceable way present, asserts `fill_req_o` and `busy_o` from the next cycle. It presents the address with its offset bits zeroed on `fill_addr_o` and holds both until the cycle `fill_ack_i` is sampled high. At that edge the tag is written into the victim way as valid and locked.
- R4: The victim way is chosen in this order: an invalid way (way 0 before way 1); otherwise the single unlocked way when the other is locked; otherwise the way named by the set's LRU bit. After the fill, the LRU bit names the other way.
- R5: A load-and-lock miss in a set whose two ways are both locked sets `err_o[1]`, starts no fill and leaves the set unchanged.
- R6: A load-and-lock written with `cinh_i` high sets `err_o[0]`, starts no fill and changes no lock, tag or LRU state, even on a hit.
- R7: Both error bits are sticky until software writes a 1 to the matching bit of `err_clr_i`. If a set and a clear of the same bit fall in one cycle, the set wins.
- R8: Unlock block clears the lock bit of a hitting block in one cycle and leaves it valid. On a miss it changes nothing and reports no error.
- R9: Unlock all clears every lock bit in one cycle and leaves valid bits, tags and LRU bits unchanged.
- R10: Invalidate all clears the valid bit of every unlocked block and keeps locked blocks valid. It sets each set's LRU bit to 1 when only way 0 is locked, and to 0 otherwise.
- R11: While `busy_o` is high, address writes and command writes are ignored.
- R12: Reset clears `busy_o`, `fill_req_o`, `err_o` and the address register. It leaves tags, valid, lock and LRU bits as they were, so software must run unlock all followed by invalidate all to empty the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of control state |
| addr_wr_i | input | 1 | Load the address register |
| addr_i | input | ADDR_W | Address to load |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_i | input | 4 | Command code |
| cinh_i | input | 1 | Addressed line is caching-inhibited (sampled with the command) |
| err_clr_i | input | 2 | Write-one-to-clear for the error bits |
| busy_o | output | 1 | A line fill is outstanding |
| err_o | output | 2 | Sticky errors: bit 0 inhibited pin, bit 1 set fully locked |
| fill_req_o | output | 1 | Line-fill request |
| fill_addr_o | output | ADDR_W | Line-aligned fill address |
| fill_ack_i | input | 1 | Fill complete |
| probe_addr_i | input | ADDR_W | Address to probe |
| probe_hit_o | output | 1 | Probe address is present |
| probe_way_o | output | 1 | Way holding the probed block |
| probe_lock_o | output | 1 | Probed block is locked |
| probe_lru_o | output | 1 | LRU bit of the probed set |

## Verification
Two functions can meet in one cycle. The first pair is an error flag being set by a rejected pin request and software clearing the same flag. The bench writes an inhibited load-and-lock in the same cycle as a clear of bit 0 and expects the flag to remain set. The second pair is an outstanding fill and a new command or address write. The bench writes an unlock and a new address while the fill is pending, then checks that the previously locked block stays locked and that the filled line lands at the original address.

// File: rtl/cl_pkg.sv
package cl_pkg;

   typedef enum logic [3:0] {
      CMD_LDLOCK     = 4'b0110,
      CMD_UNLOCK     = 4'b1000,
      CMD_UNLOCK_ALL = 4'b1010,
      CMD_INVAL_ALL  = 4'b1100
   } cl_cmd_e;

   typedef struct packed {
      logic ldlock;
      logic unlock;
      logic unlock_all;
      logic inval_all;
   } cl_op_t;

   localparam int unsigned CL_WAYS = 2;

endpackage

// File: rtl/cl_cmd_decode.sv
module cl_cmd_decode
   import cl_pkg::*;
(
   input  logic         cmd_wr_i,
   input  logic [3:0]   cmd_i,
   input  logic         busy_i,
   output cl_op_t       op_o
);

   always_comb begin
      op_o = '0;
      if (cmd_wr_i && !busy_i) begin
         case (cmd_i)
            CMD_LDLOCK:     op_o.ldlock     = 1'b1;
            CMD_UNLOCK:     op_o.unlock     = 1'b1;
            CMD_UNLOCK_ALL: op_o.unlock_all = 1'b1;
            CMD_INVAL_ALL:  op_o.inval_all  = 1'b1;
            default:        op_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/cl_way_state.sv
module cl_way_state #(
   parameter int unsigned SETS  = 8,
   parameter int unsigned IDX_W = 3,
   parameter int unsigned TAG_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  lkp_idx_i,
   input  logic [TAG_W-1:0]  lkp_tag_i,
   output logic              lkp_hit_o,
   output logic              lkp_valid_o,
   output logic              lkp_lock_o,
   input  logic [IDX_W-1:0]  prb_idx_i,
   input  logic [TAG_W-1:0]  prb_tag_i,
   output logic              prb_hit_o,
   output logic              prb_lock_o,
   input  logic              set_lock_i,
   input  logic              clr_lock_i,
   input  logic              clr_all_lock_i,
   input  logic              inval_all_i,
   input  logic              fill_i,
   input  logic [IDX_W-1:0]  fill_idx_i,
   input  logic [TAG_W-1:0]  fill_tag_i,
   output logic [SETS-1:0]   lock_vec_o
);

   logic [TAG_W-1:0] tag_q [SETS];
   logic [SETS-1:0]  valid_q;
   logic [SETS-1:0]  lock_q;

   // State arrays are deliberately left out of reset.
   always_ff @(posedge clk) begin
      if (fill_i) begin
         tag_q[fill_idx_i]   <= fill_tag_i;
         valid_q[fill_idx_i] <= 1'b1;
         lock_q[fill_idx_i]  <= 1'b1;
      end
      if (set_lock_i)     lock_q[lkp_idx_i] <= 1'b1;
      if (clr_lock_i)     lock_q[lkp_idx_i] <= 1'b0;
      if (clr_all_lock_i) lock_q <= '0;
      if (inval_all_i)    valid_q <= valid_q & lock_q;
   end

   assign lkp_valid_o = valid_q[lkp_idx_i];
   assign lkp_lock_o  = lock_q[lkp_idx_i];
   assign lkp_hit_o   = valid_q[lkp_idx_i] && (tag_q[lkp_idx_i] == lkp_tag_i);
   assign prb_hit_o   = valid_q[prb_idx_i] && (tag_q[prb_idx_i] == prb_tag_i);
   assign prb_lock_o  = lock_q[prb_idx_i];
   assign lock_vec_o  = lock_q;

   // R2
   lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_lock_i |=> lock_q[$past(lkp_idx_i)]);

   // R8
   unlock_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_lock_i |=> !lock_q[$past(lkp_idx_i)] && valid_q[$past(lkp_idx_i)]);

   // R9
   unlock_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all_lock_i |=> (lock_q == '0) && $stable(valid_q));

   genvar s;
   generate
      for (s = 0; s < SETS; s++) begin : g_inv_chk
         // R10
         inval_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            inval_all_i |=> !(valid_q[s] && !lock_q[s]));
      end
   endgenerate

endmodule

// File: rtl/cl_victim_sel.sv
module cl_victim_sel (
   input  logic [1:0] valid_i,
   input  logic [1:0] lock_i,
   input  logic       lru_i,
   output logic       way_o,
   output logic       blocked_o
);

   assign blocked_o = &lock_i;

   always_comb begin
      if (!valid_i[0])      way_o = 1'b0;
      else if (!valid_i[1]) way_o = 1'b1;
      else if (lock_i[0])   way_o = 1'b1;
      else if (lock_i[1])   way_o = 1'b0;
      else                  way_o = lru_i;
   end

endmodule

// File: rtl/cache_lock_ctrl.sv
module cache_lock_ctrl
   import cl_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned SETS       = 8,
   parameter int unsigned LINE_BYTES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              cmd_wr_i,
   input  logic [3:0]        cmd_i,
   input  logic              cinh_i,
   input  logic [1:0]        err_clr_i,
   output logic              busy_o,
   output logic [1:0]        err_o,
   output logic              fill_req_o,
   output logic [ADDR_W-1:0] fill_addr_o,
   input  logic              fill_ack_i,
   input  logic [ADDR_W-1:0] probe_addr_i,
   output logic              probe_hit_o,
   output logic              probe_way_o,
   output logic              probe_lock_o,
   output logic              probe_lru_o
);

   localparam int unsigned IDX_W = $clog2(SETS);
   localparam int unsigned OFF_W = $clog2(LINE_BYTES);
   localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;

   generate
      if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
         $error("SETS must be a power of two, at least 2");
      end
      if (LINE_BYTES < 2 || (1 << OFF_W) != LINE_BYTES) begin : g_bad_line
         $error("LINE_BYTES must be a power of two, at least 2");
      end
      if (ADDR_W <= IDX_W + OFF_W) begin : g_bad_addr
         $error("ADDR_W leaves no tag bits");
      end
   endgenerate

   cl_op_t              op;
   logic [ADDR_W-1:0]   addr_q;
   logic [ADDR_W-1:0]   fill_addr_q;
   logic                busy_q;
   logic                victim_q;
   logic [1:0]          err_q;
   logic [SETS-1:0]     lru_q;

   logic [IDX_W-1:0]    lkp_idx, prb_idx, fill_idx;
   logic [TAG_W-1:0]    lkp_tag, prb_tag, fill_tag;

   logic [CL_WAYS-1:0]  hit, valid, lock, prb_hit, prb_lock;
   logic [CL_WAYS-1:0]  set_lock, clr_lock, fill_we;
   logic [SETS-1:0]     lock_vec [CL_WAYS];

   logic any_hit, hit_way, victim_w, blocked, fill_done;
   logic ll_inh, ll_hit, ll_blocked, ll_miss_go;

   assign lkp_idx  = addr_q[OFF_W +: IDX_W];
   assign lkp_tag  = addr_q[ADDR_W-1 -: TAG_W];
   assign prb_idx  = probe_addr_i[OFF_W +: IDX_W];
   assign prb_tag  = probe_addr_i[ADDR_W-1 -: TAG_W];
   assign fill_idx = fill_addr_q[OFF_W +: IDX_W];
   assign fill_tag = fill_addr_q[ADDR_W-1 -: TAG_W];

   cl_cmd_decode u_dec (
      .cmd_wr_i (cmd_wr_i),
      .cmd_i    (cmd_i),
      .busy_i   (busy_q),
      .op_o     (op)
   );

   assign any_hit    = |hit;
   assign hit_way    = hit[1];
   assign fill_done  = busy_q && fill_ack_i;
   assign ll_inh     = op.ldlock && cinh_i;
   assign ll_hit     = op.ldlock && !cinh_i && any_hit;
   assign ll_blocked = op.ldlock && !cinh_i && !any_hit && blocked;
   assign ll_miss_go = op.ldlock && !cinh_i && !any_hit && !blocked;

   genvar w;
   generate
      for (w = 0; w < CL_WAYS; w++) begin : g_way
         assign set_lock[w] = ll_hit && hit[w];
         assign clr_lock[w] = op.unlock && hit[w];
         assign fill_we[w]  = fill_done && (victim_q == w[0]);

         cl_way_state #(
            .SETS  (SETS),
            .IDX_W (IDX_W),
            .TAG_W (TAG_W)
         ) u_way (
            .clk            (clk),
            .rst_n          (rst_n),
            .lkp_idx_i      (lkp_idx),
            .lkp_tag_i      (lkp_tag),
            .lkp_hit_o      (hit[w]),
            .lkp_valid_o    (valid[w]),
            .lkp_lock_o     (lock[w]),
            .prb_idx_i      (prb_idx),
            .prb_tag_i      (prb_tag),
            .prb_hit_o      (prb_hit[w]),
            .prb_lock_o     (prb_lock[w]),
            .set_lock_i     (set_lock[w]),
            .clr_lock_i     (clr_lock[w]),
            .clr_all_lock_i (op.unlock_all),
            .inval_all_i    (op.inval_all),
            .fill_i         (fill_we[w]),
            .fill_idx_i     (fill_idx),
            .fill_tag_i     (fill_tag),
            .lock_vec_o     (lock_vec[w])
         );
      end
   endgenerate

   cl_victim_sel u_vic (
      .valid_i   (valid),
      .lock_i    (lock),
      .lru_i     (lru_q[lkp_idx]),
      .way_o     (victim_w),
      .blocked_o (blocked)
   );

   // Control state: reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q      <= '0;
         fill_addr_q <= '0;
         busy_q      <= 1'b0;
         victim_q    <= 1'b0;
         err_q       <= '0;
      end else begin
         if (addr_wr_i && !busy_q) addr_q <= addr_i;
         if (ll_miss_go) begin
            busy_q      <= 1'b1;
            victim_q    <= victim_w;
            fill_addr_q <= {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
         end else if (fill_done) begin
            busy_q <= 1'b0;
         end
         err_q[0] <= ll_inh     || (err_q[0] && !err_clr_i[0]);
         err_q[1] <= ll_blocked || (err_q[1] && !err_clr_i[1]);
      end
   end

   // Replacement pointers: not reset.
   always_ff @(posedge clk) begin
      if (fill_done) lru_q[fill_idx] <= ~victim_q;
      if (ll_hit)    lru_q[lkp_idx]  <= ~hit_way;
      if (op.inval_all) lru_q <= lock_vec[0] & ~lock_vec[1];
   end

   assign busy_o       = busy_q;
   assign fill_req_o   = busy_q;
   assign fill_addr_o  = fill_addr_q;
   assign err_o        = err_q;
   assign probe_hit_o  = |prb_hit;
   assign probe_way_o  = prb_hit[1];
   assign probe_lock_o = |(prb_hit & prb_lock);
   assign probe_lru_o  = lru_q[prb_idx];

   // R3
   fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !fill_ack_i |=> busy_q && $stable(fill_addr_q));

   // R3
   fill_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && fill_ack_i |=> !busy_q);

   // R5
   full_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ll_blocked |=> err_q[1] && !busy_q);

   // R6
   inh_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ll_inh |=> err_q[0] && !busy_q);

   // R7
   sticky_inh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q[0] && !err_clr_i[0] |=> err_q[0]);

   // R7
   sticky_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q[1] && !err_clr_i[1] |=> err_q[1]);

   // R11
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> $stable(addr_q));

   // R4
   lru_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_done |=> lru_q[$past(fill_idx)] != $past(victim_q));

endmodule

// File: tb/cache_lock_ctrl_tb.sv
module cache_lock_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_wr_i = 1'b0;
   logic [15:0] addr_i = '0;
   logic        cmd_wr_i = 1'b0;
   logic [3:0]  cmd_i = '0;
   logic        cinh_i = 1'b0;
   logic [1:0]  err_clr_i = '0;
   logic        busy_o;
   logic [1:0]  err_o;
   logic        fill_req_o;
   logic [15:0] fill_addr_o;
   logic        fill_ack_i = 1'b0;
   logic [15:0] probe_addr_i = '0;
   logic        probe_hit_o, probe_way_o, probe_lock_o, probe_lru_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #4 clk = ~clk;

   cache_lock_ctrl u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .addr_wr_i    (addr_wr_i),
      .addr_i       (addr_i),
      .cmd_wr_i     (cmd_wr_i),
      .cmd_i        (cmd_i),
      .cinh_i       (cinh_i),
      .err_clr_i    (err_clr_i),
      .busy_o       (busy_o),
      .err_o        (err_o),
      .fill_req_o   (fill_req_o),
      .fill_addr_o  (fill_addr_o),
      .fill_ack_i   (fill_ack_i),
      .probe_addr_i (probe_addr_i),
      .probe_hit_o  (probe_hit_o),
      .probe_way_o  (probe_way_o),
      .probe_lock_o (probe_lock_o),
      .probe_lru_o  (probe_lru_o)
   );

   // code[43:40] addr[39:24] cinh[23] paddr[22:7] hit[6] way[5] lock[4] lru[3] err[2:1] fill[0]
   localparam int NV = 20;
   localparam logic [43:0] VEC [NV] = '{
      {4'h6,16'h0080,1'b0,16'h0080,1'b1,1'b0,1'b1,1'b1,2'd0,1'b1},
      {4'h6,16'h0100,1'b0,16'h0100,1'b1,1'b1,1'b1,1'b0,2'd0,1'b1},
      {4'h6,16'h0180,1'b0,16'h0180,1'b0,1'b0,1'b0,1'b0,2'd2,1'b0},
      {4'h8,16'h0100,1'b0,16'h0100,1'b1,1'b1,1'b0,1'b0,2'd2,1'b0},
      {4'h8,16'h0280,1'b0,16'h0080,1'b1,1'b0,1'b1,1'b0,2'd2,1'b0},
      {4'h6,16'h0080,1'b0,16'h0080,1'b1,1'b0,1'b1,1'b1,2'd2,1'b0},
      {4'h6,16'h0210,1'b1,16'h0210,1'b0,1'b0,1'b0,1'b0,2'd3,1'b0},
      {4'hC,16'h0000,1'b0,16'h0100,1'b0,1'b0,1'b0,1'b1,2'd3,1'b0},
      {4'h0,16'h0000,1'b0,16'h0080,1'b1,1'b0,1'b1,1'b1,2'd3,1'b0},
      {4'h6,16'h0300,1'b0,16'h0300,1'b1,1'b1,1'b1,1'b0,2'd3,1'b1},
      {4'hA,16'h0000,1'b0,16'h0300,1'b1,1'b1,1'b0,1'b0,2'd3,1'b0},
      {4'hC,16'h0000,1'b0,16'h0080,1'b0,1'b0,1'b0,1'b0,2'd3,1'b0},
      {4'h6,16'h03A0,1'b0,16'h03A0,1'b1,1'b0,1'b1,1'b1,2'd3,1'b1},
      {4'h6,16'h0420,1'b0,16'h0420,1'b1,1'b1,1'b1,1'b0,2'd3,1'b1},
      {4'h8,16'h03A0,1'b0,16'h03A0,1'b1,1'b0,1'b0,1'b0,2'd3,1'b0},
      {4'h6,16'h04A0,1'b0,16'h04A0,1'b1,1'b0,1'b1,1'b1,2'd3,1'b1},
      {4'h0,16'h0000,1'b0,16'h03A0,1'b0,1'b0,1'b0,1'b1,2'd3,1'b0},
      {4'hA,16'h0000,1'b0,16'h04A0,1'b1,1'b0,1'b0,1'b1,2'd3,1'b0},
      {4'h6,16'h0520,1'b0,16'h0520,1'b1,1'b1,1'b1,1'b0,2'd3,1'b1},
      {4'h0,16'h0000,1'b0,16'h04A0,1'b1,1'b0,1'b0,1'b0,2'd3,1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic string code_tag(input logic [3:0] c, input logic ci, input logic f);
      case (c)
         4'h6:    return ci ? "R6" : (f ? "R3" : "R2");
         4'h8:    return "R8";
         4'hA:    return "R9";
         4'hC:    return "R10";
         default: return "R1";
      endcase
   endfunction

   // Writes the address, then the command; completes any fill with an ack.
   task automatic run_cmd(input logic [3:0] c, input logic [15:0] a, input logic ci,
                          input logic exp_fill, input string tag);
      @(negedge clk);
      addr_wr_i = 1'b1; addr_i = a;
      @(negedge clk);
      addr_wr_i = 1'b0; cmd_wr_i = 1'b1; cmd_i = c; cinh_i = ci;
      @(negedge clk);
      cmd_wr_i = 1'b0; cinh_i = 1'b0;
      chk({tag, " fill_req"}, 32'(fill_req_o), 32'(exp_fill));
      if (exp_fill && fill_req_o) begin
         chk("R3 fill_addr", 32'(fill_addr_o), 32'(a));
         repeat (2) @(negedge clk);
         chk("R3 held busy", 32'(busy_o), 32'd1);
         fill_ack_i = 1'b1;
         @(negedge clk);
         fill_ack_i = 1'b0;
         chk("R3 busy end", 32'(busy_o), 32'd0);
      end
   endtask

   task automatic probe(input logic [15:0] pa, input logic eh, input logic ew,
                        input logic el, input logic elru, input string tag);
      probe_addr_i = pa;
      #1;
      chk({tag, " hit"}, 32'(probe_hit_o), 32'(eh));
      if (eh) begin
         chk({tag, " way"}, 32'(probe_way_o), 32'(ew));
         chk({tag, " lock"}, 32'(probe_lock_o), 32'(el));
      end
      chk("R4 lru", 32'(probe_lru_o), 32'(elru));
   endtask

   initial begin : watchdog
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 busy", 32'(busy_o), 32'd0);
      chk("R12 fill_req", 32'(fill_req_o), 32'd0);
      chk("R12 err", 32'(err_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: empty the cache with unlock all then invalidate all
      run_cmd(4'hA, 16'h0000, 1'b0, 1'b0, "R9");
      run_cmd(4'hC, 16'h0000, 1'b0, 1'b0, "R10");
      probe(16'h0080, 1'b0, 1'b0, 1'b0, 1'b0, "R10");

      for (int i = 0; i < NV; i++) begin
         logic [43:0] v;
         string t;
         v = VEC[i];
         t = code_tag(v[43:40], v[23], v[0]);
         run_cmd(v[43:40], v[39:24], v[23], v[0], t);
         probe(v[22:7], v[6], v[5], v[4], v[3], t);
         chk((v[23] ? "R6 err" : (v[2:1] == 2'd2 && i == 2) ? "R5 err" : "R7 err"),
             32'(err_o), 32'(v[2:1]));
      end

      // R7: write-one-to-clear of bit 0 only
      @(negedge clk);
      err_clr_i = 2'b01;
      @(negedge clk);
      err_clr_i = 2'b00;
      chk("R7 clear bit0", 32'(err_o), 32'd2);

      // R7: set and clear of bit 0 in one cycle, set wins
      @(negedge clk);
      addr_wr_i = 1'b1; addr_i = 16'h0210;
      @(negedge clk);
      addr_wr_i = 1'b0; cmd_wr_i = 1'b1; cmd_i = 4'h6; cinh_i = 1'b1; err_clr_i = 2'b01;
      @(negedge clk);
      cmd_wr_i = 1'b0; cinh_i = 1'b0; err_clr_i = 2'b00;
      chk("R7 set wins", 32'(err_o), 32'd3);
      chk("R6 no fill", 32'(fill_req_o), 32'd0);
      @(negedge clk);
      err_clr_i = 2'b11;
      @(negedge clk);
      err_clr_i = 2'b00;
      chk("R7 clear both", 32'(err_o), 32'd0);

      // R11: commands and address writes ignored while a fill is pending
      @(negedge clk);
      addr_wr_i = 1'b1; addr_i = 16'h05B0;
      @(negedge clk);
      addr_wr_i = 1'b0; cmd_wr_i = 1'b1; cmd_i = 4'h6;
      @(negedge clk);
      chk("R3 busy set", 32'(busy_o), 32'd1);
      addr_wr_i = 1'b1; addr_i = 16'h0520; cmd_wr_i = 1'b1; cmd_i = 4'h8;
      @(negedge clk);
      addr_wr_i = 1'b0; cmd_wr_i = 1'b1; cmd_i = 4'h8;
      @(negedge clk);
      cmd_wr_i = 1'b0;
      chk("R11 fill_addr kept", 32'(fill_addr_o), 32'h05B0);
      fill_ack_i = 1'b1;
      @(negedge clk);
      fill_ack_i = 1'b0;
      probe(16'h0520, 1'b1, 1'b1, 1'b1, 1'b0, "R11");
      probe(16'h05B0, 1'b1, 1'b0, 1'b1, 1'b1, "R11");

      // R1: unknown code on a locked block changes nothing
      run_cmd(4'h2, 16'h05B0, 1'b0, 1'b0, "R1");
      probe(16'h05B0, 1'b1, 1'b0, 1'b1, 1'b1, "R1");
      chk("R1 err", 32'(err_o), 32'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule